// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block produces the strobes that drive a single-scan colour passive LCD panel fed through a 16-bit data path. The path is split into an upper byte and a lower byte. The design derives a pixel tick from the memory clock by dividing it by one, two, three or four. The tick advances a horizontal counter and a vertical line counter. From those two counters the block places the edges of the frame strobe, the line strobe, the shift clock and the AC-modulation toggle.

The line period is set by two fields, each counted in groups of eight pixel ticks. One field sets the active width and the other sets the blanking width. The last-line field sets how many lines make up a frame. A pixel source presents a 16-bit word together with a ready flag. The block pulses a request during the single memory clock in which it captures that word. The upper half of the word goes to the upper byte and the lower half goes to the lower byte.

All configuration fields are copied into shadow registers at reset and again at each frame start. A write made part-way through a frame therefore takes effect only from the next frame.

Top module: `lcd_panel_timing`

## Requirements
- R1: A pixel tick occurs once every `pclk_div`+1 memory clocks, where `pclk_div` is the shadowed 2-bit value. Every strobe and data output changes only in the clock that follows a tick.
- R2: A line lasts 8×(`act_width`+1) + 8×(`blank_width`+1) ticks. A `blank_width` below 3 is treated as 3.
- R3: `line_strb` is high for the last 9 ticks of every line. Its falling edge marks horizontal position 0 of the next line.
- R4: A frame holds `last_line`+1 lines, with `last_line` ≥ 1. `frame_strb` rises at tick 9 of the last line and falls at tick 9 of line 0, so it straddles the falling edge of `line_strb`.
- R5: `shift_clk` first rises at tick 18 after the falling edge of `line_strb`. It is high for 3 ticks and low for 2, a period of 5 ticks. A rise is issued only while its falling edge lands no later than 8×(`act_width`+1)+16 ticks into the line.
- R6: In the tick that raises `shift_clk`, `pix_req` is high for that one memory clock. `data_hi` then takes `pix_data[15:8]` and `data_lo` takes `pix_data[7:0]`, or both take zero if `pix_rdy` is low. Both bytes hold steady through the following falling edge.
- R7: Once the shift clock stops, both data bytes return to zero 5 ticks after the last rise. They stay at zero, and `shift_clk` stays low, until the next line's first rise.
- R8: `ac_mod` toggles exactly once per frame, at tick 8×(`act_width`+1)−1 of line 0.
- R9: `pclk_div`, `act_width`, `blank_width` and `last_line` are sampled only at reset and at the tick where the last line wraps to line 0.
- R10: While reset is held, all strobes, both data bytes and `pix_req` are zero. After reset, counting starts at position 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_div | input | 2 | Pixel tick divide select, ratio = value+1 |
| act_width | input | 7 | Active part of a line, in units of 8 ticks, minus one |
| blank_width | input | 5 | Blanking part of a line, in units of 8 ticks, minus one |
| last_line | input | 10 | Number of lines per frame minus one |
| pix_data | input | 16 | Pixel word from the source |
| pix_rdy | input | 1 | Source has a word available |
| pix_req | output | 1 | Word captured in this clock |
| frame_strb | output | 1 | Frame start strobe |
| line_strb | output | 1 | Line strobe |
| shift_clk | output | 1 | Data shift clock |
| ac_mod | output | 1 | AC-modulation toggle |
| data_hi | output | 8 | Upper data byte |
| data_lo | output | 8 | Lower data byte |

## Verification
The bench rewrites the configuration in the middle of a frame and checks that the line period stays unchanged until the next frame. A design that sampled the fields directly would produce a truncated or stretched line at that point. It sets a blanking field below the clamp and uses a one-group active width that allows only a single shift. A missing clamp would push the last shift edge past the line strobe, and an off-by-one in the stop rule would add or drop a shift. Source stalls are inserted so that the zero-fill on a missing word is exercised. Every divide ratio is used, so a tick that reloaded the divider wrongly would shift each edge by whole memory clocks.

// File: rtl/lcdpt_pkg.sv
package lcdpt_pkg;
  localparam int DIV_W    = 2;
  localparam int ACT_W    = 7;
  localparam int BLANK_W  = 5;
  localparam int VL_W     = 10;
  localparam int HC_W     = $clog2(((1 << ACT_W) + (1 << BLANK_W)) * 8);

  typedef struct packed {
    logic [DIV_W-1:0]   div;
    logic [ACT_W-1:0]   act;
    logic [BLANK_W-1:0] blank;
    logic [VL_W-1:0]    vlast;
  } cfg_t;
endpackage

// File: rtl/lcdpt_tick.sv
module lcdpt_tick
  import lcdpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] dcnt;

  assign tick = (dcnt >= div);

  always_ff @(posedge clk) begin
    if (rst)       dcnt <= '0;
    else if (tick) dcnt <= '0;
    else           dcnt <= dcnt + 1'b1;
  end
endmodule

// File: rtl/lcdpt_hvcount.sv
module lcdpt_hvcount
  import lcdpt_pkg::*;
#(
  parameter int MIN_BLANK = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  cfg_t            cfg_in,
  output cfg_t            cfg,
  output logic [HC_W-1:0] line_len,
  output logic [HC_W-1:0] hc_nx,
  output logic [VL_W-1:0] ln_nx
);
  logic [HC_W-1:0] hc;
  logic [VL_W-1:0] ln;
  cfg_t            cfg_fix;
  logic            wrap_h, wrap_v;

  always_comb begin
    cfg_fix = cfg_in;
    if (cfg_in.blank < BLANK_W'(MIN_BLANK)) cfg_fix.blank = BLANK_W'(MIN_BLANK);
  end

  assign line_len = (HC_W'(cfg.act) + HC_W'(cfg.blank) + HC_W'(2)) << 3;
  assign wrap_h   = (hc == line_len - HC_W'(1));
  assign wrap_v   = wrap_h && (ln == cfg.vlast);

  always_comb begin
    hc_nx = hc;
    ln_nx = ln;
    if (tick) begin
      if (wrap_h) begin
        hc_nx = '0;
        ln_nx = wrap_v ? '0 : ln + 1'b1;
      end else begin
        hc_nx = hc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc  <= '0;
      ln  <= '0;
      cfg <= cfg_fix;
    end else begin
      hc <= hc_nx;
      ln <= ln_nx;
      if (tick && wrap_v) cfg <= cfg_fix;
    end
  end
endmodule

// File: rtl/lcdpt_strobes.sv
module lcdpt_strobes
  import lcdpt_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int FLINE_TS     = 9,
  parameter int FRAME_HOLD   = 9,
  parameter int SHIFT_START  = 18,
  parameter int SHIFT_PERIOD = 5,
  parameter int SHIFT_HIGH   = 3,
  parameter int SHIFT_TAIL   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  cfg_t              cfg,
  input  logic [HC_W-1:0]   line_len,
  input  logic [HC_W-1:0]   hc_nx,
  input  logic [VL_W-1:0]   ln_nx,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_rdy,
  output logic              pix_req,
  output logic              frame_o,
  output logic              line_o,
  output logic              shift_o,
  output logic              mod_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int PH_W = $clog2(SHIFT_PERIOD);

  logic [PH_W-1:0] ph, ph_nx;
  logic [HC_W-1:0] disp_len, rise_lim, rise_pos;
  logic            in_win, active, at_rise, load, clear;

  assign disp_len = (HC_W'(cfg.act) + HC_W'(1)) << 3;
  assign rise_lim = disp_len + HC_W'(SHIFT_TAIL - SHIFT_HIGH);

  always_comb begin
    ph_nx = ph;
    if (tick) begin
      if (hc_nx == HC_W'(SHIFT_START))   ph_nx = '0;
      else if (hc_nx > HC_W'(SHIFT_START))
        ph_nx = (ph == PH_W'(SHIFT_PERIOD - 1)) ? '0 : ph + 1'b1;
    end
  end

  assign in_win   = (hc_nx >= HC_W'(SHIFT_START));
  assign rise_pos = hc_nx - HC_W'(ph_nx);
  assign active   = in_win && (rise_pos <= rise_lim);
  assign at_rise  = tick && in_win && (ph_nx == '0);
  assign load     = at_rise && active;
  assign clear    = at_rise && !active;
  assign pix_req  = load;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      frame_o <= 1'b0;
      line_o  <= 1'b0;
      shift_o <= 1'b0;
      mod_o   <= 1'b0;
      word_o  <= '0;
    end else if (tick) begin
      ph      <= ph_nx;
      line_o  <= (hc_nx >= line_len - HC_W'(FLINE_TS));
      frame_o <= ((ln_nx == cfg.vlast) && (hc_nx >= HC_W'(FRAME_HOLD))) ||
                 ((ln_nx == '0) && (hc_nx < HC_W'(FRAME_HOLD)));
      shift_o <= active && (ph_nx < PH_W'(SHIFT_HIGH));
      if ((ln_nx == '0) && (hc_nx == disp_len - HC_W'(1))) mod_o <= ~mod_o;
      if (load)       word_o <= pix_rdy ? pix_data : '0;
      else if (clear) word_o <= '0;
    end
  end
endmodule

// File: rtl/lcd_panel_timing.sv
module lcd_panel_timing
  import lcdpt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    pclk_div,
  input  logic [ACT_W-1:0]    act_width,
  input  logic [BLANK_W-1:0]  blank_width,
  input  logic [VL_W-1:0]     last_line,
  input  logic [DATA_W-1:0]   pix_data,
  input  logic                pix_rdy,
  output logic                pix_req,
  output logic                frame_strb,
  output logic                line_strb,
  output logic                shift_clk,
  output logic                ac_mod,
  output logic [DATA_W/2-1:0] data_hi,
  output logic [DATA_W/2-1:0] data_lo
);
  cfg_t              cfg_in, cfg;
  logic              tick;
  logic [HC_W-1:0]   line_len, hc_nx;
  logic [VL_W-1:0]   ln_nx;
  logic [DATA_W-1:0] word;

  assign cfg_in = '{div: pclk_div, act: act_width, blank: blank_width, vlast: last_line};

  lcdpt_tick u_tick (
    .clk(clk), .rst(rst), .div(cfg.div), .tick(tick)
  );

  lcdpt_hvcount u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cfg_in(cfg_in), .cfg(cfg),
    .line_len(line_len), .hc_nx(hc_nx), .ln_nx(ln_nx)
  );

  lcdpt_strobes #(.DATA_W(DATA_W)) u_strb (
    .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .line_len(line_len),
    .hc_nx(hc_nx), .ln_nx(ln_nx), .pix_data(pix_data), .pix_rdy(pix_rdy),
    .pix_req(pix_req), .frame_o(frame_strb), .line_o(line_strb),
    .shift_o(shift_clk), .mod_o(ac_mod), .word_o(word)
  );

  assign data_hi = word[DATA_W-1:DATA_W/2];
  assign data_lo = word[DATA_W/2-1:0];
endmodule

// File: rtl/lcd_panel_timing_chk.sv
module lcd_panel_timing_chk #(
  parameter int DATA_W   = 16,
  parameter int FLINE_TS = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                frame_strb,
  input logic                line_strb,
  input logic                shift_clk,
  input logic                ac_mod,
  input logic [DATA_W/2-1:0] data_hi,
  input logic [DATA_W/2-1:0] data_lo
);
  logic [7:0] fl_cnt;

  always_ff @(posedge clk) begin
    if (rst || !line_strb) fl_cnt <= '0;
    else if (tick)         fl_cnt <= fl_cnt + 1'b1;
  end

  AST_OUTPUTS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({frame_strb, line_strb, shift_clk, ac_mod, data_hi, data_lo})); // R1
  AST_LINE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(line_strb) |-> (fl_cnt == 8'(FLINE_TS))); // R3
  AST_DATA_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_clk) |-> $stable({data_hi, data_lo})); // R6
  AST_IDLE_UNDER_LINE: assert property (@(posedge clk) disable iff (rst)
    line_strb |-> (!shift_clk && data_hi == '0 && data_lo == '0)); // R7
  AST_MOD_OUTSIDE_LINE: assert property (@(posedge clk) disable iff (rst)
    $changed(ac_mod) |-> !line_strb); // R8
endmodule

bind lcd_panel_timing lcd_panel_timing_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .frame_strb(frame_strb),
  .line_strb(line_strb), .shift_clk(shift_clk), .ac_mod(ac_mod),
  .data_hi(data_hi), .data_lo(data_lo)
);

// File: tb/lcd_panel_timing_tb.sv
`timescale 1ns/1ps
module lcd_panel_timing_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  pclk_div = 2'd0;
  logic [6:0]  act_width = 7'd3;
  logic [4:0]  blank_width = 5'd4;
  logic [9:0]  last_line = 10'd2;
  logic [15:0] pix_data = '0;
  logic        pix_rdy = 1'b1;
  logic        pix_req, frame_strb, line_strb, shift_clk, ac_mod;
  logic [7:0]  data_hi, data_lo;

  int checks = 0, errors = 0, cyc = 0, src = 0;
  bit gaps = 0, m_valid = 0, req_seen = 0, done = 0;

  int m_dcnt, m_hc, m_ln, m_div, m_h, m_n, m_vl;
  bit m_fl, m_fr, m_sh, m_mod;
  logic [15:0] m_word;

  always #2.5 clk = ~clk;

  lcd_panel_timing u_dut (
    .clk(clk), .rst(rst), .pclk_div(pclk_div), .act_width(act_width),
    .blank_width(blank_width), .last_line(last_line), .pix_data(pix_data),
    .pix_rdy(pix_rdy), .pix_req(pix_req), .frame_strb(frame_strb),
    .line_strb(line_strb), .shift_clk(shift_clk), .ac_mod(ac_mod),
    .data_hi(data_hi), .data_lo(data_lo)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 20) $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic void latch();
    m_div = pclk_div;
    m_h   = act_width;
    m_n   = (blank_width < 3) ? 3 : blank_width;
    m_vl  = last_line;
  endfunction

  // Behavioural reference model, advanced on every memory clock.
  always @(posedge clk) begin
    int len, disp, p;
    bit act, exp_req;
    cyc++;
    if (rst) begin
      m_dcnt = 0; m_hc = 0; m_ln = 0; latch();
      m_fl = 0; m_fr = 0; m_sh = 0; m_mod = 0; m_word = '0;
      m_valid = 1;
    end else begin
      exp_req = 0;
      if (m_dcnt >= m_div) begin
        m_dcnt = 0;
        len = 8 * (m_h + 1) + 8 * (m_n + 1);
        if (m_hc == len - 1) begin
          m_hc = 0;
          if (m_ln == m_vl) begin m_ln = 0; latch(); end
          else m_ln++;
        end else m_hc++;
        len  = 8 * (m_h + 1) + 8 * (m_n + 1);
        disp = 8 * (m_h + 1);
        m_fl = (m_hc >= len - 9);
        m_fr = (m_ln == m_vl && m_hc >= 9) || (m_ln == 0 && m_hc < 9);
        if (m_hc >= 18) begin
          p    = (m_hc - 18) % 5;
          act  = (m_hc - p + 3) <= disp + 16;
          m_sh = act && (p < 3);
          if (p == 0) begin
            if (act) begin m_word = pix_rdy ? pix_data : 16'h0; exp_req = 1; end
            else m_word = '0;
          end
        end else m_sh = 0;
        if (m_ln == 0 && m_hc == disp - 1) m_mod = !m_mod;
      end else m_dcnt++;
      chk(req_seen == exp_req, "R6 pix_req", req_seen, exp_req);
      if (req_seen && pix_rdy) src++;
    end
  end

  // Source drive and comparison, away from the active edge.
  always @(negedge clk) begin
    pix_data = {~src[7:0], src[7:0]};
    pix_rdy  = !(gaps && (cyc % 7 == 3));
    #1;
    req_seen = pix_req;
    if (m_valid && !done) begin
      chk(line_strb == m_fl,  "R3 line_strb",  line_strb,  m_fl);
      chk(frame_strb == m_fr, "R4 frame_strb", frame_strb, m_fr);
      chk(shift_clk == m_sh,  "R5 shift_clk",  shift_clk,  m_sh);
      chk(ac_mod == m_mod,    "R8 ac_mod",     ac_mod,     m_mod);
      chk({data_hi, data_lo} == m_word, (m_word == 0) ? "R7 data" : "R6 data",
          {data_hi, data_lo}, m_word);
    end
  end

  task automatic measure(input int exp_clk, input string rq);
    int t0;
    @(posedge line_strb); t0 = cyc;
    @(posedge line_strb);
    chk(cyc - t0 == exp_clk, rq, cyc - t0, exp_clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({pix_req, frame_strb, line_strb, shift_clk, ac_mod, data_hi, data_lo} == '0,
        "R10 reset state", {frame_strb, line_strb, shift_clk, ac_mod}, 0);
    @(negedge clk) rst = 1'b0;
    // Line 0 of the first frame: change fields mid-frame.
    @(negedge frame_strb);
    @(negedge clk);
    pclk_div = 2'd2; act_width = 7'd5; blank_width = 5'd1;
    measure(72, "R9 old period kept mid-frame");
    @(negedge frame_strb);
    measure(80 * 3, "R2 R1 clamp and divide by 3");
    @(negedge clk);
    pclk_div = 2'd1; act_width = 7'd0; blank_width = 5'd6; last_line = 10'd1; gaps = 1;
    @(negedge frame_strb);
    @(negedge frame_strb);
    measure(64 * 2, "R2 R1 single-shift line");
    @(negedge clk);
    pclk_div = 2'd3; act_width = 7'd20; blank_width = 5'd31; last_line = 10'd3;
    @(negedge frame_strb);
    measure(424 * 4, "R2 R1 wide line divide by 4");
    @(negedge frame_strb);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule